// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This block keeps the page selector that a small microcontroller core uses to reach its special-function registers. The selector sits at the top of a three-entry stack: the active page, a middle entry and a bottom entry. When the core accepts an interrupt, the stack moves down one entry and the active page is loaded with the page assigned to the interrupt source. The handler therefore starts on the page it needs without running any code to select it.

On return from interrupt the stack moves back up, so the interrupted code gets its page back. A higher-priority interrupt that arrives during a handler pushes again, which gives two levels of nesting. Software can read and write every entry, and a control bit, through a small register port. Software can also turn the automatic push and pop off.

Top module: `page_stack_top`

## Requirements
- R1: After reset, the active, middle and bottom entries all read 0x00 and the auto-stack enable bit reads 1.
- R2: On an accepted interrupt while enabled, the active entry takes the page assigned to the source. An even source index gives page 0x00 and an odd source index gives page 0x0F.
- R3: On the same push, the old active value moves to the middle entry and the old middle value moves to the bottom entry. The old bottom value is lost, including a value software wrote there, and no flag is raised.
- R4: On a return strobe while enabled with no interrupt accepted in the same cycle, the middle entry moves to active and the bottom entry moves to middle. The bottom entry keeps its value.
- R5: The register port uses address 0 for active, 1 for middle, 2 for bottom and 3 for control, where bit 0 is the enable. A write takes effect at the next clock edge. Reads are combinational and return 0 in the unused control bits.
- R6: While the enable bit is 0, interrupt and return strobes leave all three entries unchanged.
- R7: When a push and a pop happen in the same cycle, the push wins. In any cycle with an effective push or pop, software writes to entries 0 to 2 are dropped. Writes to the control register are always applied.
- R8: Two interrupts in a row nest. The second push places the first handler's page in the middle entry and the interrupted code's page in the bottom entry, and two returns restore them in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_take_i | input | 1 | Interrupt accepted strobe, one cycle |
| irq_src_i | input | 4 | Index of the accepted interrupt source |
| irq_ret_i | input | 1 | Return-from-interrupt strobe, one cycle |
| reg_addr_i | input | 2 | Register port address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |

## Verification
If the active entry is wrong after a push, the fault shows up on an address-0 read in the first cycle after the vector. An error in the middle or bottom entry stays hidden until one or two returns bring it up to the active entry, or until software reads that entry directly. The bench therefore reads all three entries after every operation, so a corrupted shift shows up one cycle after it happens and not several returns later. Pushes three deep that overwrite a bottom value written by software check that the discard follows R3.

// File: rtl/page_stack_pkg.sv
package page_stack_pkg;
  localparam int unsigned PAGE_W  = 8;
  localparam int unsigned SRC_W   = 4;
  localparam int unsigned DEPTH   = 3;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned CTRL_ADDR = DEPTH;

  localparam logic [PAGE_W-1:0] PAGE_EVEN = 8'h00;
  localparam logic [PAGE_W-1:0] PAGE_ODD  = 8'h0F;

  typedef logic [PAGE_W-1:0] page_t;
endpackage

// File: rtl/page_map.sv
module page_map
  import page_stack_pkg::*;
#(
  parameter int unsigned N_SRC = 1 << SRC_W
) (
  input  logic [SRC_W-1:0] src_i,
  output page_t            page_o
);
  page_t table_q [N_SRC];

  // constant table computed per source index
  for (genvar s = 0; s < N_SRC; s++) begin : g_tab
    assign table_q[s] = (s % 2 == 1) ? PAGE_ODD : PAGE_EVEN;
  end

  assign page_o = table_q[src_i];
endmodule

// File: rtl/page_stack_level.sv
module page_stack_level
  import page_stack_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  logic  pop_i,
  input  logic  wr_i,
  input  page_t wdata_i,
  input  page_t above_i,
  input  page_t below_i,
  output page_t q_o
);
  page_t q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (push_i) q_q <= above_i;
    else if (pop_i)  q_q <= below_i;
    else if (wr_i)   q_q <= wdata_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/page_stack_top.sv
module page_stack_top
  import page_stack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_take_i,
  input  logic [SRC_W-1:0]  irq_src_i,
  input  logic              irq_ret_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [PAGE_W-1:0] reg_wdata_i,
  output logic [PAGE_W-1:0] reg_rdata_o
);
  page_t lvl   [DEPTH];
  page_t above [DEPTH];
  page_t below [DEPTH];
  page_t map_page;
  logic  en_q;
  logic  push, pop;

  assign push = irq_take_i & en_q;
  assign pop  = irq_ret_i & en_q & ~irq_take_i;

  page_map u_map (
    .src_i  (irq_src_i),
    .page_o (map_page)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    if (i == 0) begin : g_head
      assign above[i] = map_page;
    end else begin : g_mid
      assign above[i] = lvl[i-1];
    end
    if (i == DEPTH - 1) begin : g_tail
      assign below[i] = lvl[i]; // bottom holds on pop
    end else begin : g_up
      assign below[i] = lvl[i+1];
    end

    page_stack_level u_lvl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push),
      .pop_i   (pop),
      .wr_i    (reg_wr_i && (reg_addr_i == ADDR_W'(i))),
      .wdata_i (reg_wdata_i),
      .above_i (above[i]),
      .below_i (below[i]),
      .q_o     (lvl[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else if (reg_wr_i && reg_addr_i == ADDR_W'(CTRL_ADDR)) en_q <= reg_wdata_i[0];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(CTRL_ADDR)) reg_rdata_o = {{(PAGE_W-1){1'b0}}, en_q};
    else begin
      for (int k = 0; k < DEPTH; k++)
        if (reg_addr_i == ADDR_W'(k)) reg_rdata_o = lvl[k];
    end
  end

  AST_PUSH_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_i && en_q) |=> (lvl[0] == (($past(irq_src_i) % 2 == 1) ? PAGE_ODD : PAGE_EVEN))); // R2
  AST_PUSH_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_i && en_q) |=> (lvl[1] == $past(lvl[0]) && lvl[2] == $past(lvl[1]))); // R3
  AST_POP_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !irq_take_i && en_q) |=> (lvl[0] == $past(lvl[1]) && lvl[1] == $past(lvl[2]) && $stable(lvl[2]))); // R4
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !reg_wr_i) |=> ($stable(lvl[0]) && $stable(lvl[1]) && $stable(lvl[2]))); // R6
  AST_CTRL_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(CTRL_ADDR)) |=> (en_q == $past(reg_wdata_i[0]))); // R7
endmodule

// File: tb/page_stack_top_tb_top.sv
`timescale 1ns/100ps
module page_stack_top_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       irq_take = 0, irq_ret = 0, reg_wr = 0;
  logic [3:0] irq_src = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;

  int n_tests = 0, n_fail = 0;
  logic [7:0] m [3];
  logic       m_en;

  always #2 clk = ~clk;

  page_stack_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_take_i(irq_take), .irq_src_i(irq_src),
    .irq_ret_i(irq_ret), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  function automatic logic [7:0] exp_page(input logic [3:0] s);
    return s[0] ? 8'h0F : 8'h00;
  endfunction

  task automatic check(input string tag, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #0.3;
    n_tests++;
    if (reg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 3; k++) check(tag, k[1:0], m[k]);
    check(tag, 2'd3, {7'b0, m_en});
  endtask

  // one operation cycle; model updated from the requirements
  task automatic op(input logic take, input logic [3:0] src, input logic ret,
                    input logic wr, input logic [1:0] a, input logic [7:0] d, input string tag);
    logic pe, po;
    @(negedge clk);
    irq_take = take; irq_src = src; irq_ret = ret;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    pe = take && m_en;
    po = ret && m_en && !take;
    if (pe) begin m[2] = m[1]; m[1] = m[0]; m[0] = exp_page(src); end
    else if (po) begin m[0] = m[1]; m[1] = m[2]; end
    else if (wr && a != 2'd3) m[a] = d;
    if (wr && a == 2'd3) m_en = d[0];
    @(negedge clk);
    irq_take = 0; irq_ret = 0; reg_wr = 0;
    check_all(tag);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    m[0] = 0; m[1] = 0; m[2] = 0; m_en = 1;
    r = $urandom(32'h1234);
    #9 rst_n = 1;
    @(negedge clk);
    check_all("R1");
    op(0, 0, 0, 1, 2'd0, 8'h3C, "R5");
    op(0, 0, 0, 1, 2'd2, 8'hA5, "R5");
    op(1, 4'd5, 0, 0, 0, 0, "R2");
    op(1, 4'd4, 0, 0, 0, 0, "R8");
    op(1, 4'd3, 0, 0, 0, 0, "R3");
    op(0, 0, 1, 0, 0, 0, "R4");
    op(0, 0, 1, 0, 0, 0, "R8");
    op(1, 4'd2, 1, 1, 2'd1, 8'h77, "R7");
    op(0, 0, 1, 1, 2'd0, 8'h55, "R7");
    op(0, 0, 0, 1, 2'd3, 8'h00, "R5");
    op(1, 4'd7, 0, 0, 0, 0, "R6");
    op(0, 0, 1, 0, 0, 0, "R6");
    op(1, 4'd9, 0, 1, 2'd3, 8'h01, "R7");
    op(1, 4'd9, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 500; i++) begin
      r = $urandom;
      op(r[0] & r[1], r[7:4], r[2] & r[3], r[8] & r[9], r[11:10],
         (r[11:10] == 2'd3) ? {7'b0, (r[12] | r[13])} : r[23:16], "R3");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule